// File: doc/BRIEF.md
# Two-Channel Reloadable Byte DMA Engine

This block moves single bytes between locations of a 16-bit address space over an 8-bit memory bus. It has two independent channels. Each channel keeps a working source pointer, destination pointer and transfer count. Behind each of these three registers sits a shadow latch that can be copied back into the working register on command. The same channel can therefore be re-armed for a repeated pattern without software rewriting every byte.

A CPU programs the engine through a small byte-wide register port. The channel registers share one window of addresses, and bit 7 of the index register decides which channel that window reaches. Each transfer is a read beat followed by a write beat. Pointers step after the write, by +1 or -1 or not at all. The count decrements on every byte, and its wrap from 0x0000 to 0xFFFF sets a sticky terminal-count flag. When configured to, the wrap also switches the channel off.

Top module: `dma2_reload`

## Requirements
- R1: After a synchronous reset, reads of the behaviour byte, the enable byte and the index register all return 0x00, `tc_flag` is 0, and neither `mem_rd` nor `mem_wr` is active.
- R2: Behaviour bit 1 enables source stepping and bit 0 chooses its direction (0 = +1, 1 = -1). The source pointer changes once, after each write beat. With bit 1 clear it keeps its value.
- R3: Behaviour bit 3 enables destination stepping and bit 2 chooses its direction (0 = +1, 1 = -1). With bit 3 clear the destination pointer keeps its value.
- R4: With behaviour bit 4 at 0, a CPU write to a low or high byte of source, destination or count updates both the working register and its latch. With bit 4 at 1, only the latch changes, and a read still returns the old working value.
- R5: A write of the behaviour byte with bit 6 at 1 copies all three latches of that channel into the working registers in the same clock, whether or not a transfer is in progress. Bit 6 always reads as 0.
- R6: The count decrements by one after every transfer. A transfer that starts with count 0x0000 leaves 0xFFFF and sets the channel's sticky `tc_flag` bit. Writing 1 to bit n of the index register clears the flag of channel n.
- R7: With behaviour bit 5 at 1, the transfer that wraps the count clears the channel enable (bit 7 of the enable byte) on the same clock edge. With bit 5 at 0, the enable stays set.
- R8: A request on a channel whose enable is 0 causes no bus activity.
- R9: A transfer is one cycle with `mem_rd` high and `mem_addr` equal to the source pointer, then one cycle with `mem_wr` high, `mem_addr` equal to the destination pointer and `mem_wdata` equal to the byte read. Outside transfers, `mem_addr` and `mem_wdata` are 0.
- R10: With behaviour bit 7 at 0 (cycle-steal), every transfer is followed by one idle bus cycle, so writes occur every 3 cycles. With bit 7 at 1 (burst), transfers run back to back, with writes every 2 cycles, while the request stays high and the channel stays enabled.
- R11: When both channels request while enabled at an arbitration point, channel 0 is served.
- R12: Index register bit 7 selects the channel (0 or 1) that register addresses 0x1 to 0x8 read and write. The map is: 0x0 index, 0x1 behaviour byte, 0x2 enable byte, 0x3/0x4 source low/high, 0x5/0x6 destination low/high, 0x7/0x8 count low/high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 4 | Register address |
| cpu_we | input | 1 | Register write strobe |
| cpu_wdata | input | 8 | Register write data |
| cpu_rdata | output | 8 | Register read data (combinational) |
| dma_req | input | 2 | Transfer request, one bit per channel |
| tc_flag | output | 2 | Sticky terminal-count flag per channel |
| mem_rd | output | 1 | Memory read beat |
| mem_wr | output | 1 | Memory write beat |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid in the read beat's cycle |

## Verification
The assertions assume that memory returns read data combinationally in the same cycle as the read beat. They also assume that the CPU does not write the count register, a behaviour byte or an enable byte of a channel in the very cycle in which that channel finishes a write beat. The properties that could be disturbed by such writes exclude those cycles explicitly. The stimulus issues register writes only while the bus is idle, or while requests of the written channel are low, and the bench memory returns a pure function of the address in the same cycle.

// File: rtl/dma2_pkg.sv
package dma2_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int NCH    = 2;
    localparam int RA_W   = 4;
    localparam int CH_W   = (NCH > 1) ? $clog2(NCH) : 1;

    // per-channel behaviour byte, bit 7 down to bit 0
    typedef struct packed {
        logic burst;
        logic reload;
        logic dis_uf;
        logic latch_only;
        logic dst_step;
        logic dst_dec;
        logic src_step;
        logic src_dec;
    } mode_t;

    typedef enum logic [RA_W-1:0] {
        RA_INDEX  = 4'h0,
        RA_MODE   = 4'h1,
        RA_CTRL   = 4'h2,
        RA_SRC_LO = 4'h3,
        RA_SRC_HI = 4'h4,
        RA_DST_LO = 4'h5,
        RA_DST_HI = 4'h6,
        RA_CNT_LO = 4'h7,
        RA_CNT_HI = 4'h8
    } reg_addr_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } bus_state_e;

    localparam logic [DATA_W-1:0] MODE_WMASK = 8'hBF;

    function automatic logic [ADDR_W-1:0] step_addr(
        input logic [ADDR_W-1:0] a,
        input logic              en,
        input logic              dec
    );
        if (!en)
            return a;
        return dec ? a - ADDR_W'(1) : a + ADDR_W'(1);
    endfunction

endpackage

// File: rtl/dma2_chan.sv
module dma2_chan
    import dma2_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [RA_W-1:0]   wr_reg,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              xfer_done,
    input  logic              tc_clr,
    output logic [ADDR_W-1:0] src,
    output logic [ADDR_W-1:0] dst,
    output logic [ADDR_W-1:0] cnt,
    output mode_t             mode,
    output logic              enable,
    output logic              tc,
    output logic              keep_en
);

    logic [ADDR_W-1:0] src_l, dst_l, cnt_l;
    logic              wrap;
    logic              do_reload;

    assign wrap      = xfer_done && (cnt == '0);
    assign keep_en   = enable && !(mode.dis_uf && cnt == '0);
    assign do_reload = wr_en && (wr_reg == RA_MODE) && wr_data[6];

    always_ff @(posedge clk) begin
        if (rst) begin
            src    <= '0;
            dst    <= '0;
            cnt    <= '0;
            src_l  <= '0;
            dst_l  <= '0;
            cnt_l  <= '0;
            mode   <= '0;
            enable <= 1'b0;
            tc     <= 1'b0;
        end else begin
            // lowest priority: end-of-transfer update
            if (xfer_done) begin
                src <= step_addr(src, mode.src_step, mode.src_dec);
                dst <= step_addr(dst, mode.dst_step, mode.dst_dec);
                cnt <= cnt - ADDR_W'(1);
                if (wrap) begin
                    tc <= 1'b1;
                    if (mode.dis_uf)
                        enable <= 1'b0;
                end
            end
            if (tc_clr)
                tc <= 1'b0;
            // CPU byte writes override the transfer update
            if (wr_en) begin
                case (wr_reg)
                    RA_MODE:   mode   <= mode_t'(wr_data & MODE_WMASK);
                    RA_CTRL:   enable <= wr_data[7];
                    RA_SRC_LO: begin
                        src_l[7:0] <= wr_data;
                        if (!mode.latch_only) src[7:0] <= wr_data;
                    end
                    RA_SRC_HI: begin
                        src_l[15:8] <= wr_data;
                        if (!mode.latch_only) src[15:8] <= wr_data;
                    end
                    RA_DST_LO: begin
                        dst_l[7:0] <= wr_data;
                        if (!mode.latch_only) dst[7:0] <= wr_data;
                    end
                    RA_DST_HI: begin
                        dst_l[15:8] <= wr_data;
                        if (!mode.latch_only) dst[15:8] <= wr_data;
                    end
                    RA_CNT_LO: begin
                        cnt_l[7:0] <= wr_data;
                        if (!mode.latch_only) cnt[7:0] <= wr_data;
                    end
                    RA_CNT_HI: begin
                        cnt_l[15:8] <= wr_data;
                        if (!mode.latch_only) cnt[15:8] <= wr_data;
                    end
                    default: ;
                endcase
            end
            // highest priority: reload from shadow latches
            if (do_reload) begin
                src <= src_l;
                dst <= dst_l;
                cnt <= cnt_l;
            end
        end
    end

    assert_wrap_sets_tc_R6: assert property (@(posedge clk) disable iff (rst)
        wrap && !tc_clr |=> tc);

    assert_count_steps_R6: assert property (@(posedge clk) disable iff (rst)
        xfer_done && !wr_en |=> cnt == $past(cnt) - ADDR_W'(1));

    assert_wrap_disables_R7: assert property (@(posedge clk) disable iff (rst)
        wrap && mode.dis_uf && !(wr_en && wr_reg == RA_CTRL) |=> !enable);

    assert_wrap_keeps_en_R7: assert property (@(posedge clk) disable iff (rst)
        wrap && !mode.dis_uf && !(wr_en && wr_reg == RA_CTRL) |=> enable == $past(enable));

    assert_reload_src_R5: assert property (@(posedge clk) disable iff (rst)
        do_reload |=> src == $past(src_l));

endmodule

// File: rtl/dma2_seq.sv
module dma2_seq
    import dma2_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NCH-1:0]             req,
    input  logic [NCH-1:0]             enable,
    input  logic [NCH-1:0]             burst,
    input  logic [NCH-1:0]             keep_en,
    input  logic [NCH-1:0][ADDR_W-1:0] src,
    input  logic [NCH-1:0][ADDR_W-1:0] dst,
    input  logic [DATA_W-1:0]          mem_rdata,
    output logic                       mem_rd,
    output logic                       mem_wr,
    output logic [ADDR_W-1:0]          mem_addr,
    output logic [DATA_W-1:0]          mem_wdata,
    output logic [NCH-1:0]             done
);

    bus_state_e        st;
    logic [CH_W-1:0]   act;
    logic [DATA_W-1:0] data_q;
    logic [NCH-1:0]    elig;
    logic              any;
    logic [CH_W-1:0]   pick;

    // fixed priority: the lowest channel index wins
    always_comb begin
        elig = req & enable;
        any  = 1'b0;
        pick = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (elig[i]) begin
                any  = 1'b1;
                pick = CH_W'(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            act    <= '0;
            data_q <= '0;
        end else begin
            case (st)
                ST_IDLE: if (any) begin
                    act <= pick;
                    st  <= ST_READ;
                end
                ST_READ: begin
                    data_q <= mem_rdata;
                    st     <= ST_WRITE;
                end
                ST_WRITE: st <= (burst[act] && req[act] && keep_en[act]) ? ST_READ : ST_IDLE;
                default:  st <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_rd    = (st == ST_READ);
        mem_wr    = (st == ST_WRITE);
        mem_addr  = '0;
        mem_wdata = '0;
        done      = '0;
        if (mem_rd)
            mem_addr = src[act];
        if (mem_wr) begin
            mem_addr  = dst[act];
            mem_wdata = data_q;
            done[act] = 1'b1;
        end
    end

    assert_read_then_write_R9: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> mem_wr);

    assert_write_data_R9: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> mem_wdata == $past(mem_rdata));

    assert_steal_gap_R10: assert property (@(posedge clk) disable iff (rst)
        mem_wr && !burst[act] |=> !mem_rd);

    assert_no_grant_R8: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE) && ((req & enable) == '0) |=> !mem_rd);

    assert_prio_ch0_R11: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE) && req[0] && enable[0] |=> act == '0);

endmodule

// File: rtl/dma2_reload.sv
module dma2_reload
    import dma2_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [RA_W-1:0]   cpu_addr,
    input  logic              cpu_we,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic [NCH-1:0]    dma_req,
    output logic [NCH-1:0]    tc_flag,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);

    logic [CH_W-1:0]            sel;
    logic [NCH-1:0][ADDR_W-1:0] src_w, dst_w, cnt_w;
    mode_t                      mode_w [NCH];
    logic [NCH-1:0]             en_w, keep_w, burst_w, done_w;
    logic                       idx_wr;

    assign idx_wr = cpu_we && (cpu_addr == RA_INDEX);

    always_ff @(posedge clk) begin
        if (rst)
            sel <= '0;
        else if (idx_wr)
            sel <= CH_W'(cpu_wdata[7]);
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        dma2_chan u_chan (
            .clk       (clk),
            .rst       (rst),
            .wr_en     (cpu_we && !idx_wr && (sel == CH_W'(c))),
            .wr_reg    (cpu_addr),
            .wr_data   (cpu_wdata),
            .xfer_done (done_w[c]),
            .tc_clr    (idx_wr && cpu_wdata[c]),
            .src       (src_w[c]),
            .dst       (dst_w[c]),
            .cnt       (cnt_w[c]),
            .mode      (mode_w[c]),
            .enable    (en_w[c]),
            .tc        (tc_flag[c]),
            .keep_en   (keep_w[c])
        );
        assign burst_w[c] = mode_w[c].burst;
    end

    dma2_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .req       (dma_req),
        .enable    (en_w),
        .burst     (burst_w),
        .keep_en   (keep_w),
        .src       (src_w),
        .dst       (dst_w),
        .mem_rdata (mem_rdata),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .done      (done_w)
    );

    always_comb begin
        cpu_rdata = '0;
        case (cpu_addr)
            RA_INDEX: begin
                cpu_rdata[7]       = sel[0];
                cpu_rdata[NCH-1:0] = tc_flag;
            end
            RA_MODE:   cpu_rdata = mode_w[sel];
            RA_CTRL:   cpu_rdata[7] = en_w[sel];
            RA_SRC_LO: cpu_rdata = src_w[sel][7:0];
            RA_SRC_HI: cpu_rdata = src_w[sel][15:8];
            RA_DST_LO: cpu_rdata = dst_w[sel][7:0];
            RA_DST_HI: cpu_rdata = dst_w[sel][15:8];
            RA_CNT_LO: cpu_rdata = cnt_w[sel][7:0];
            RA_CNT_HI: cpu_rdata = cnt_w[sel][15:8];
            default:   cpu_rdata = '0;
        endcase
    end

    assert_index_sel_R12: assert property (@(posedge clk) disable iff (rst)
        idx_wr |=> sel == CH_W'($past(cpu_wdata[7])));

    assert_bus_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

endmodule

// File: tb/dma2_reload_tb.sv
module dma2_reload_tb;
    import dma2_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  cpu_addr = '0;
    logic        cpu_we = 1'b0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic [1:0]  dma_req = '0;
    logic [1:0]  tc_flag;
    logic        mem_rd, mem_wr;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata;

    always #5 clk = ~clk;

    function automatic logic [7:0] memf(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    assign mem_rdata = memf(mem_addr);

    dma2_reload u_dut (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_we(cpu_we),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .dma_req(dma_req),
        .tc_flag(tc_flag), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    int n_run  = 0;
    int n_fail = 0;
    int wd     = 0;

    // ---------------- behavioural reference model ----------------
    logic [15:0] m_src [2], m_dst [2], m_cnt [2];
    logic [15:0] l_src [2], l_dst [2], l_cnt [2];
    logic [7:0]  m_mode [2];
    logic        m_en [2], m_tc [2];
    int          m_st, m_act;
    logic [7:0]  m_dq;
    logic        m_sel;

    always @(posedge clk) begin : model
        int c;
        int nxt;
        logic keep;
        logic [7:0] d;
        if (rst) begin
            for (int i = 0; i < 2; i++) begin
                m_src[i] = 0; m_dst[i] = 0; m_cnt[i] = 0;
                l_src[i] = 0; l_dst[i] = 0; l_cnt[i] = 0;
                m_mode[i] = 0; m_en[i] = 0; m_tc[i] = 0;
            end
            m_st = 0; m_act = 0; m_dq = 0; m_sel = 0;
        end else begin
            if (m_st == 2) begin
                c = m_act;
                keep = m_en[c] && !(m_mode[c][5] && m_cnt[c] == 0);
                nxt = (m_mode[c][7] && dma_req[c] && keep) ? 1 : 0;
                if (m_mode[c][1]) m_src[c] = m_mode[c][0] ? m_src[c] - 1 : m_src[c] + 1;
                if (m_mode[c][3]) m_dst[c] = m_mode[c][2] ? m_dst[c] - 1 : m_dst[c] + 1;
                if (m_cnt[c] == 0) begin
                    m_tc[c] = 1;
                    if (m_mode[c][5]) m_en[c] = 0;
                end
                m_cnt[c] = m_cnt[c] - 1;
                m_st = nxt;
            end else if (m_st == 1) begin
                m_dq = memf(m_src[m_act]);
                m_st = 2;
            end else begin
                if (dma_req[0] && m_en[0]) begin m_act = 0; m_st = 1; end
                else if (dma_req[1] && m_en[1]) begin m_act = 1; m_st = 1; end
            end
            if (cpu_we) begin
                d = cpu_wdata;
                c = int'(m_sel);
                case (cpu_addr)
                    4'h0: begin
                        m_sel = d[7];
                        if (d[0]) m_tc[0] = 0;
                        if (d[1]) m_tc[1] = 0;
                    end
                    4'h1: begin
                        m_mode[c] = d & 8'hBF;
                        if (d[6]) begin
                            m_src[c] = l_src[c]; m_dst[c] = l_dst[c]; m_cnt[c] = l_cnt[c];
                        end
                    end
                    4'h2: m_en[c] = d[7];
                    4'h3: begin l_src[c][7:0]  = d; if (!m_mode[c][4]) m_src[c][7:0]  = d; end
                    4'h4: begin l_src[c][15:8] = d; if (!m_mode[c][4]) m_src[c][15:8] = d; end
                    4'h5: begin l_dst[c][7:0]  = d; if (!m_mode[c][4]) m_dst[c][7:0]  = d; end
                    4'h6: begin l_dst[c][15:8] = d; if (!m_mode[c][4]) m_dst[c][15:8] = d; end
                    4'h7: begin l_cnt[c][7:0]  = d; if (!m_mode[c][4]) m_cnt[c][7:0]  = d; end
                    4'h8: begin l_cnt[c][15:8] = d; if (!m_mode[c][4]) m_cnt[c][15:8] = d; end
                    default: ;
                endcase
            end
        end
    end

    // per-cycle comparison of bus and flags (R9, R10 and the rest via the model)
    always @(negedge clk) begin : compare
        logic erd, ewr;
        logic [15:0] ea;
        logic [7:0] ed;
        if (!rst) begin
            erd = (m_st == 1);
            ewr = (m_st == 2);
            ea  = erd ? m_src[m_act] : (ewr ? m_dst[m_act] : 16'h0);
            ed  = ewr ? m_dq : 8'h0;
            n_run++;
            if ({mem_rd, mem_wr, mem_addr, mem_wdata, tc_flag} !==
                {erd, ewr, ea, ed, m_tc[1], m_tc[0]}) begin
                n_fail++;
                $display("FAIL R9/R10 bus at %0t: actual rd=%b wr=%b a=%h d=%h tc=%b expected rd=%b wr=%b a=%h d=%h tc=%b",
                         $time, mem_rd, mem_wr, mem_addr, mem_wdata, tc_flag,
                         erd, ewr, ea, ed, {m_tc[1], m_tc[0]});
            end
        end
    end

    always @(posedge clk) begin
        wd++;
        if (wd > 20000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected under 20000", wd);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    // ---------------- tasks ----------------
    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic rd_chk(input logic [3:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        cpu_addr = a;
        #1;
        check(cpu_rdata === exp, tag, int'(cpu_rdata), int'(exp));
    endtask

    task automatic rd16_chk(input logic [3:0] a, input logic [15:0] exp, input string tag);
        rd_chk(a, exp[7:0], tag);
        rd_chk(a + 4'd1, exp[15:8], tag);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_we = 1'b1;
        @(negedge clk);
        cpu_we = 1'b0;
    endtask

    task automatic wr16(input logic [3:0] a, input logic [15:0] v);
        wr(a, v[7:0]);
        wr(a + 4'd1, v[15:8]);
    endtask

    // hold a request for n transfers and check spacing of write beats
    task automatic run_n(input int ch, input int n, input int gap, input string tag);
        int k = 0;
        int last = -1;
        int t = 0;
        dma_req[ch] = 1'b1;
        while (k < n) begin
            @(negedge clk);
            t++;
            if (mem_wr) begin
                if (last >= 0) check(t - last == gap, tag, t - last, gap);
                last = t;
                k++;
                if (k == n) dma_req[ch] = 1'b0;
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        rd_chk(4'h1, 8'h00, "R1 mode");
        rd_chk(4'h2, 8'h00, "R1 enable");
        rd_chk(4'h0, 8'h00, "R1 index");
        check(!mem_rd && !mem_wr && tc_flag == 2'b00, "R1 bus idle", {mem_rd, mem_wr, tc_flag}, 0);

        // R2/R3/R6/R10: channel 0, source +1, destination -1, cycle-steal
        wr(4'h1, 8'h0E);
        wr16(4'h3, 16'h1000);
        wr16(4'h5, 16'h2000);
        wr16(4'h7, 16'h0002);
        wr(4'h2, 8'h80);
        run_n(0, 3, 3, "R10 cycle-steal gap");
        rd16_chk(4'h3, 16'h1003, "R2 src increment");
        rd16_chk(4'h5, 16'h1FFD, "R3 dst decrement");
        rd16_chk(4'h7, 16'hFFFF, "R6 count wrap");
        rd_chk(4'h0, 8'h01, "R6 tc set");
        rd_chk(4'h2, 8'h80, "R7 stays enabled");
        wr(4'h0, 8'h01);
        rd_chk(4'h0, 8'h00, "R6 tc cleared");

        // R4/R5/R12: channel 1, latch-only writes and reload
        wr(4'h0, 8'h80);
        wr(4'h1, 8'h10);
        wr16(4'h3, 16'h3000);
        wr16(4'h5, 16'h4000);
        wr16(4'h7, 16'h0001);
        rd16_chk(4'h3, 16'h0000, "R4 latch-only src");
        rd16_chk(4'h7, 16'h0000, "R4 latch-only cnt");
        wr(4'h1, 8'h50);
        rd_chk(4'h1, 8'h10, "R5 reload bit reads 0");
        rd16_chk(4'h3, 16'h3000, "R5 reload src");
        rd16_chk(4'h5, 16'h4000, "R5 reload dst");
        rd16_chk(4'h7, 16'h0001, "R5 reload cnt");
        wr(4'h0, 8'h00);
        rd16_chk(4'h3, 16'h1003, "R12 index selects ch0");
        wr(4'h0, 8'h80);
        rd16_chk(4'h3, 16'h3000, "R12 index selects ch1");

        // R2/R3 fixed addressing, R10 burst timing on channel 1
        wr(4'h1, 8'h90);
        wr(4'h2, 8'h80);
        run_n(1, 2, 2, "R10 burst gap");
        rd16_chk(4'h3, 16'h3000, "R2 src fixed");
        rd16_chk(4'h5, 16'h4000, "R3 dst fixed");
        rd16_chk(4'h7, 16'hFFFF, "R6 ch1 count wrap");
        rd_chk(4'h0, 8'h82, "R6 ch1 tc");
        wr(4'h1, 8'hD0);
        rd16_chk(4'h7, 16'h0001, "R5 reload after run");
        rd_chk(4'h1, 8'h90, "R5 mode readback");

        // R7/R8: channel 0, burst with disable on wrap
        wr(4'h0, 8'h02);
        wr(4'h1, 8'hA2);
        wr16(4'h3, 16'h5000);
        wr16(4'h7, 16'h0002);
        run_n(0, 3, 2, "R10 burst gap ch0");
        rd_chk(4'h2, 8'h00, "R7 disabled on wrap");
        rd16_chk(4'h3, 16'h5003, "R2 src after burst");
        rd_chk(4'h0, 8'h01, "R6 ch0 tc again");
        begin
            int seen = 0;
            dma_req[0] = 1'b1;
            repeat (6) begin
                @(negedge clk);
                if (mem_rd || mem_wr) seen++;
            end
            dma_req[0] = 1'b0;
            check(seen == 0, "R8 request ignored while disabled", seen, 0);
        end
        wr(4'h0, 8'h03);

        // R11: fixed priority
        wr(4'h1, 8'h00);
        wr16(4'h3, 16'h6000);
        wr(4'h2, 8'h80);
        wr(4'h0, 8'h80);
        wr(4'h1, 8'h00);
        wr16(4'h3, 16'h7000);
        begin
            int ch1_reads = 0;
            @(negedge clk);
            dma_req = 2'b11;
            @(negedge clk);
            while (!mem_rd) @(negedge clk);
            check(mem_addr == 16'h6000, "R11 channel 0 served first", int'(mem_addr), 16'h6000);
            repeat (9) begin
                @(negedge clk);
                if (mem_rd && mem_addr == 16'h7000) ch1_reads++;
            end
            check(ch1_reads == 0, "R11 channel 1 waits", ch1_reads, 0);
            dma_req[0] = 1'b0;
            repeat (4) @(negedge clk);
            while (!mem_rd) @(negedge clk);
            check(mem_addr == 16'h7000, "R11 channel 1 after release", int'(mem_addr), 16'h7000);
            @(negedge clk);
            dma_req[1] = 1'b0;
        end
        repeat (4) @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule